// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Divide-by-Eight Counter

This block counts clock edges modulo eight using a four-stage twisted-ring register, in which the inverted last stage feeds the first and every other stage copies its neighbour. The count is presented as eight one-hot decoded lines. Each line is the AND of two stage bits, so none of them spikes while the count moves. A carry line runs at one eighth of the clock rate with a 50% duty cycle, and it can clock the next counter in a ripple chain.

An active-high inhibit input freezes the count. An active-low reset, sampled on the clock, returns the counter to count zero. If an upset leaves the register in a pattern outside the eight-state ring, lock-out protection sends it back to count zero on the next enabled edge.

Top module: `johnson_div8`

## Requirements
- R1: On each rising edge with `rst_n` high and `inhibit` low, the count advances by one. Count 7 wraps to count 0. Count k is shown by `decode[k]` high.
- R2: A rising edge with `rst_n` low sets count 0 (`decode` = 8'h01, `carry_out` = 1), whatever the level of `inhibit`.
- R3: A rising edge with `rst_n` high and `inhibit` high leaves the count, `decode` and `carry_out` unchanged.
- R4: While the register holds a legal pattern, exactly one `decode` bit is high. That bit stays high for a whole clock period.
- R5: `carry_out` is high in counts 0 to 3 and low in counts 4 to 7. It rises only when the count enters 0.
- R6: The legal stage patterns (bit 3 to bit 0) for counts 0 to 7 are 0000, 0001, 0011, 0111, 1111, 1110, 1100 and 1000. Any other pattern becomes count 0 on the first enabled rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset to count 0 |
| inhibit | input | 1 | High holds the count |
| decode | output | 8 | One-hot decoded count, bit k high in count k |
| carry_out | output | 1 | Divide-by-eight square wave for chaining |

## Verification
The bench runs the counter through several wraps, so a counter that skipped the wrap or decoded two lines at once would break the one-hot comparison at the 7-to-0 step. It toggles inhibit in irregular patterns and asserts reset while inhibit is high. A design that slipped a count under inhibit, or that let inhibit mask reset, would diverge from the reference count. All eight illegal stage patterns are forced into the register. A design without lock-out gating would keep circulating an illegal pattern, or take extra edges to return, and would miss the expected count 0 one edge later.

// File: rtl/jc_pkg.sv
// Shared constants and helpers for the twisted-ring counter.
// Assumes stage counts of at least two.
package jc_pkg;
    localparam int unsigned JC_DEF_STAGES = 4;

    // Number of distinct counts a ring of n stages walks through.
    function automatic int unsigned jc_counts(input int unsigned n);
        return 2 * n;
    endfunction
endpackage

// File: rtl/jc_ring.sv
// Twisted-ring register with lock-out recovery.
// It shifts toward the high stage and feeds the inverted top stage into stage 0.
// A pattern with more than one boundary between neighbouring stages is illegal,
// and it is replaced by all zeros on the next advance.
// Assumes rst_n is synchronous to clk.
module jc_ring #(
    parameter int unsigned STAGES = jc_pkg::JC_DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [STAGES-1:0] stage_q
);
    localparam int unsigned EDGES = STAGES - 1;

    logic [EDGES-1:0]  boundary;
    logic              legal;
    logic [STAGES-1:0] stage_d;

    // Mark where neighbouring stages disagree.
    assign boundary = stage_q[STAGES-2:0] ^ stage_q[STAGES-1:1];

    // Next pattern: a twisted shift when legal, otherwise a clear.
    always_comb begin
        legal   = ($countones(boundary) <= 1);
        stage_d = legal ? {stage_q[STAGES-2:0], ~stage_q[STAGES-1]} : '0;
    end

    // State register: clear on reset, move on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (advance) begin
            stage_q <= stage_d;
        end
    end
endmodule

// File: rtl/jc_decode.sv
// Two-input decoders and carry output for a twisted-ring register.
// Each count line ANDs two stage bits that differ in exactly that count.
// Carry is the inverted top stage, a registered bit, so it cannot glitch.
// Assumes the register follows the legal sequence from jc_ring.
module jc_decode #(
    parameter int unsigned STAGES = jc_pkg::JC_DEF_STAGES,
    parameter int unsigned COUNTS = jc_pkg::jc_counts(STAGES)
) (
    input  logic [STAGES-1:0] stage_q,
    output logic [COUNTS-1:0] decode,
    output logic              carry_out
);
    // One two-input gate per count line.
    for (genvar k = 0; k < COUNTS; k++) begin : g_line
        if (k == 0) begin : g_zero
            assign decode[k] = ~stage_q[STAGES-1] & ~stage_q[0];
        end else if (k < STAGES) begin : g_fill
            assign decode[k] = stage_q[k-1] & ~stage_q[k];
        end else if (k == STAGES) begin : g_full
            assign decode[k] = stage_q[STAGES-1] & stage_q[0];
        end else begin : g_drain
            assign decode[k] = ~stage_q[k-STAGES-1] & stage_q[k-STAGES];
        end
    end

    // Carry is high for the first half of the cycle.
    assign carry_out = ~stage_q[STAGES-1];
endmodule

// File: rtl/johnson_div8.sv
// Top level of the self-correcting divide-by-eight counter.
// It combines the ring register with the decoders. Inhibit gates advancing;
// reset is synchronous, active low, and wins over inhibit.
module johnson_div8 #(
    parameter int unsigned STAGES = jc_pkg::JC_DEF_STAGES,
    parameter int unsigned COUNTS = jc_pkg::jc_counts(STAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inhibit,
    output logic [COUNTS-1:0] decode,
    output logic              carry_out
);
    logic [STAGES-1:0] ring_q;

    // Ring register with lock-out recovery.
    jc_ring #(.STAGES(STAGES)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (~inhibit),
        .stage_q (ring_q)
    );

    // Glitch-free count lines and carry.
    jc_decode #(.STAGES(STAGES), .COUNTS(COUNTS)) u_dec (
        .stage_q   (ring_q),
        .decode    (decode),
        .carry_out (carry_out)
    );
endmodule

// File: rtl/johnson_div8_chk.sv
// Port-level property checker for johnson_div8, attached with bind.
module johnson_div8_chk #(
    parameter int unsigned COUNTS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inhibit,
    input logic [COUNTS-1:0] decode,
    input logic              carry_out
);
    // An enabled step always lands on exactly one count line.
    assert_onehot_after_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit |=> $onehot(decode));

    // The last count wraps to count zero.
    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!inhibit && decode[COUNTS-1]) |=> decode[0]);

    // Inhibit freezes every output.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> ($stable(decode) && $stable(carry_out)));

    // Carry rises only when the count enters zero.
    assert_carry_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carry_out) |-> decode[0]);

    // Reset taken with inhibit low lands on count zero. The bench covers reset under inhibit.
    assert_reset_R2: assert property (@(posedge clk)
        (!rst_n && !inhibit) |=> (decode == COUNTS'(1) && carry_out));
endmodule

bind johnson_div8 johnson_div8_chk #(.COUNTS(COUNTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inhibit   (inhibit),
    .decode    (decode),
    .carry_out (carry_out)
);

// File: tb/johnson_div8_test.sv
`timescale 1ns/1ps
module johnson_div8_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inhibit = 1'b0;
    logic [7:0] decode;
    logic       carry_out;

    int  checks = 0;
    int  fails = 0;
    bit  finished = 1'b0;
    bit  started = 1'b0;
    int  model_count = 0;
    bit  upset = 1'b0;
    bit  recovered = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    johnson_div8 uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .inhibit   (inhibit),
        .decode    (decode),
        .carry_out (carry_out)
    );

    // Reference model: integer count updated on each rising edge.
    always @(posedge clk) begin
        recovered = 1'b0;
        if (!rst_n) begin
            model_count = 0;
            upset = 1'b0;
        end else if (!inhibit) begin
            if (upset) begin
                model_count = 0;
                upset = 1'b0;
                recovered = 1'b1;
            end else begin
                model_count = (model_count + 1) % 8;
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model mid-cycle, away from the active edge.
    always @(negedge clk) begin
        if (started && !upset && !finished) begin
            check(recovered ? "R6" : cur_req, decode, 8'(1) << model_count);
            check("R5 carry", {7'd0, carry_out}, {7'd0, model_count < 4});
            check("R4 onehot", 8'($countones(decode)), 8'd1);
        end
    end

    function automatic bit legal_pattern(input int p);
        return p == 0 || p == 1 || p == 3 || p == 7 || p == 15 ||
               p == 14 || p == 12 || p == 8;
    endfunction

    // Upset the register with a pattern under cover of reset, then release (R6).
    task automatic inject(input int pat);
        @(negedge clk);
        rst_n = 1'b0;
        inhibit = 1'b1;
        @(negedge clk);
        #1;
        upset = 1'b1;
        force uut.u_ring.stage_q = 4'(pat);
        #0.5;
        release uut.u_ring.stage_q;
        rst_n = 1'b1;
        inhibit = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        started = 1'b1;
        cur_req = "R2";
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        repeat (30) @(negedge clk);
        cur_req = "R3";
        for (int i = 0; i < 48; i++) begin
            inhibit = (i % 3 == 1) || (i % 7 == 0);
            @(negedge clk);
        end
        inhibit = 1'b0;
        repeat (5) @(negedge clk);
        cur_req = "R2";
        rst_n = 1'b0;
        inhibit = 1'b1;
        @(negedge clk);
        check("R2 reset under inhibit", decode, 8'h01);
        rst_n = 1'b1;
        inhibit = 1'b0;
        cur_req = "R1";
        repeat (20) @(negedge clk);
        cur_req = "R6";
        for (int p = 0; p < 16; p++) begin
            if (!legal_pattern(p)) inject(p);
        end
        cur_req = "R1";
        repeat (10) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule